// File: doc/BRIEF.md
# Write-Invalidate Line Disconnect Control

This block sits on the target side of a bridge port that faces the initiator. It watches each data word of a posted memory write as it is accepted into the posted-write buffer. For write-and-invalidate bursts it tracks the word address against a line size that software programs at run time. It asks the bus interface to signal a target disconnect on the word that completes an aligned cache line. The buffer is never overrun, because a disconnect is also requested with the word that takes the last free slot, whatever the command.

When a write-and-invalidate burst closes anywhere other than a line boundary, the block hands the queue a plain memory write instead. The burst may stop because the buffer filled or because the initiator ended it. The block also hands over a plain memory write when the burst began off a line boundary or when the line size register holds an unusable value. In all these cases a write-and-invalidate entry never covers a partial line. The final command code for each transaction appears one cycle after the closing word, with a one-cycle strobe. Buffer storage and downstream forwarding belong to other blocks.

Top module: `wi_line_disc`

## Requirements
- R1: The line size input `cls_i` counts 32-bit words. It is usable only at 1, 2, 4, 8, 16 or 32. Any other value (0, 3, 12, 64, ...) turns every write-and-invalidate (code 4'hF) into a memory write (code 4'h7).
- R2: Take a write-and-invalidate burst that starts aligned under a usable line size. `disc_o` is raised with the accepted word whose word address has all bits of (`cls_i`-1) set, and never on an earlier word unless R3 applies.
- R3: For any command, `disc_o` is raised with every accepted word presented while `free_i` is 1 or less.
- R4: A write-and-invalidate burst that closes on its line-completing word is enqueued as 4'hF. One that closes on any other word is enqueued as 4'h7, whether it closed through a full buffer or through `last_i`.
- R5: A write-and-invalidate burst whose first word address has any bit of (`cls_i`-1) set is enqueued as 4'h7. It gets no line-boundary disconnect.
- R6: Any command other than 4'hF is enqueued unchanged and gets no line-boundary disconnect.
- R7: `cmd_vld_o` is high for exactly the cycle after a closing word. A closing word is an accepted word with `disc_o` or `last_i` high. `cmd_o` then carries the final code. At all other times `cmd_vld_o` is low.
- R8: `cmd_i` is sampled only on the word marked by `first_i`. Its value on later words of the burst has no effect.
- R9: After reset, with no word presented, `cmd_vld_o` and `disc_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | A data word is accepted this cycle |
| first_i | input | 1 | The accepted word opens a new transaction |
| last_i | input | 1 | The initiator ends the transaction with this word |
| cmd_i | input | 4 | Bus command code of the transaction |
| addr_i | input | AW (30) | Word address of the accepted word |
| free_i | input | FW (7) | Free slots in the posted-write buffer before this word |
| cls_i | input | CLS_W (8) | Line size register, in words |
| disc_o | output | 1 | Request target disconnect with this word |
| cmd_o | output | 4 | Final command code for the closed transaction |
| cmd_vld_o | output | 1 | `cmd_o` is valid this cycle |

## Verification
The assertions assume the following about the inputs. `first_i` marks the opening word of each transaction. `cls_i` does not change inside a burst. `free_i` is at least 1 whenever a word is accepted. No word follows a disconnect until a new transaction opens. The stimulus keeps to these rules. It fixes the line size for the whole burst and lowers the free count by one per word from a start value of at least one. It stops driving words at the first expected disconnect or at the initiator's final word, and inserts an idle cycle before the next burst opens.

// File: rtl/wi_line_pkg.sv
package wi_line_pkg;
   typedef logic [3:0] bus_cmd_t;
   localparam bus_cmd_t CMD_MEM_WR     = 4'h7;
   localparam bus_cmd_t CMD_MEM_WR_INV = 4'hF;
endpackage

// File: rtl/wi_line_cfg.sv
module wi_line_cfg #(
   parameter int CLS_W    = 8,
   parameter int MAX_LINE = 32
) (
   input  logic [CLS_W-1:0] cls_i,
   output logic             legal_o,
   output logic [CLS_W-1:0] mask_o
);
   localparam int LVLS = $clog2(MAX_LINE) + 1;

   if ((MAX_LINE & (MAX_LINE - 1)) != 0 || MAX_LINE < 1) begin : g_bad_max
      $error("MAX_LINE must be a power of two");
   end
   if (MAX_LINE >= (1 << CLS_W)) begin : g_bad_width
      $error("CLS_W too narrow for MAX_LINE");
   end

   logic [LVLS-1:0] size_hit;

   for (genvar g = 0; g < LVLS; g++) begin : g_size
      assign size_hit[g] = (cls_i == CLS_W'(1 << g));
   end

   assign legal_o = |size_hit;
   assign mask_o  = cls_i - CLS_W'(1);
endmodule

// File: rtl/wi_line_pos.sv
module wi_line_pos #(
   parameter int CLS_W = 8
) (
   input  logic [CLS_W-1:0] addr_low_i,
   input  logic [CLS_W-1:0] mask_i,
   output logic             at_end_o,
   output logic             at_start_o
);
   logic [CLS_W-1:0] offset;

   assign offset     = addr_low_i & mask_i;
   assign at_end_o   = (offset == mask_i);
   assign at_start_o = (offset == '0);
endmodule

// File: rtl/wi_space_chk.sv
module wi_space_chk #(
   parameter int FW      = 7,
   parameter int RESERVE = 1
) (
   input  logic [FW-1:0] free_i,
   output logic          last_slot_o
);
   if (RESERVE < 0 || RESERVE >= (1 << FW)) begin : g_bad_reserve
      $error("RESERVE out of range for FW");
   end

   if (RESERVE == 0) begin : g_never
      assign last_slot_o = 1'b0;
   end else begin : g_cmp
      assign last_slot_o = (free_i <= FW'(RESERVE));
   end
endmodule

// File: rtl/wi_line_disc.sv
module wi_line_disc
   import wi_line_pkg::*;
#(
   parameter int AW       = 30,
   parameter int FW       = 7,
   parameter int CLS_W    = 8,
   parameter int MAX_LINE = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic             first_i,
   input  logic             last_i,
   input  logic [3:0]       cmd_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [FW-1:0]    free_i,
   input  logic [CLS_W-1:0] cls_i,
   output logic             disc_o,
   output logic [3:0]       cmd_o,
   output logic             cmd_vld_o
);
   if (AW < CLS_W) begin : g_bad_aw
      $error("AW must be at least CLS_W");
   end

   logic             line_ok;
   logic [CLS_W-1:0] line_mask;
   logic             at_end;
   logic             at_start;
   logic             last_slot;

   wi_line_cfg #(.CLS_W(CLS_W), .MAX_LINE(MAX_LINE)) i_cfg (
      .cls_i   (cls_i),
      .legal_o (line_ok),
      .mask_o  (line_mask)
   );

   wi_line_pos #(.CLS_W(CLS_W)) i_pos (
      .addr_low_i (addr_i[CLS_W-1:0]),
      .mask_i     (line_mask),
      .at_end_o   (at_end),
      .at_start_o (at_start)
   );

   wi_space_chk #(.FW(FW), .RESERVE(1)) i_space (
      .free_i      (free_i),
      .last_slot_o (last_slot)
   );

   bus_cmd_t cmd_q;
   logic     mwi_q;
   bus_cmd_t cur_cmd;
   logic     start_mwi;
   logic     cur_mwi;
   logic     line_hit;
   logic     closing;
   bus_cmd_t fin_cmd;

   always_comb begin
      start_mwi = (cmd_i == CMD_MEM_WR_INV) && line_ok && at_start;
      cur_cmd   = first_i ? cmd_i : cmd_q;
      cur_mwi   = first_i ? start_mwi : mwi_q;
      line_hit  = cur_mwi && at_end;
      disc_o    = valid_i && (line_hit || last_slot);
      closing   = valid_i && (disc_o || last_i);
      if (cur_cmd == CMD_MEM_WR_INV) begin
         fin_cmd = line_hit ? CMD_MEM_WR_INV : CMD_MEM_WR;
      end else begin
         fin_cmd = cur_cmd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= CMD_MEM_WR;
         mwi_q     <= 1'b0;
         cmd_o     <= CMD_MEM_WR;
         cmd_vld_o <= 1'b0;
      end else begin
         if (valid_i && first_i) begin
            cmd_q <= cmd_i;
            mwi_q <= start_mwi;
         end
         cmd_vld_o <= closing;
         if (closing) begin
            cmd_o <= fin_cmd;
         end
      end
   end

   // R3
   full_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && last_slot) |-> disc_o);

   // R2
   line_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cur_mwi && at_end) |-> disc_o);

   // R7
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld_o |-> $past(valid_i && (disc_o || last_i)));

   // R4
   whole_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_o && cmd_o == CMD_MEM_WR_INV) |-> $past(line_ok && at_end));

   // R1
   illegal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && first_i && !line_ok) |=> !mwi_q);
endmodule

// File: tb/test_wi_line_disc.sv
module test_wi_line_disc;
   localparam int AW = 30;
   localparam int FW = 7;
   localparam int CW = 8;
   localparam logic [3:0] C_MW  = 4'h7;
   localparam logic [3:0] C_MWI = 4'hF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_i = 1'b0;
   logic          first_i = 1'b0;
   logic          last_i = 1'b0;
   logic [3:0]    cmd_i = 4'h0;
   logic [AW-1:0] addr_i = '0;
   logic [FW-1:0] free_i = '0;
   logic [CW-1:0] cls_i = '0;
   logic          disc_o;
   logic [3:0]    cmd_o;
   logic          cmd_vld_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   wi_line_disc i_wi_line_disc (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .first_i(first_i),
      .last_i(last_i), .cmd_i(cmd_i), .addr_i(addr_i), .free_i(free_i),
      .cls_i(cls_i), .disc_o(disc_o), .cmd_o(cmd_o), .cmd_vld_o(cmd_vld_o)
   );

   function automatic bit size_usable(input logic [CW-1:0] c);
      return c == 1 || c == 2 || c == 4 || c == 8 || c == 16 || c == 32;
   endfunction

   task automatic check_bit(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic check_cmd(input string tag, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s cmd got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic run_burst(input logic [3:0] c, input logic [AW-1:0] a0, input int n,
                            input logic [CW-1:0] cls, input int fr0, input string tag);
      bit            usable = size_usable(cls);
      logic [CW-1:0] mask = cls - 8'd1;
      bit            mwi = (c == C_MWI) && usable && ((a0[CW-1:0] & mask) == 8'd0);
      logic [3:0]    exp_cmd = c;
      for (int k = 0; k < n; k++) begin
         logic [AW-1:0] ad = a0 + AW'(k);
         bit bnd = mwi && ((ad[CW-1:0] & mask) == mask);
         bit full = (fr0 - k) <= 1;
         bit ends = bnd || full || (k == n - 1);
         @(negedge clk);
         valid_i = 1'b1;
         first_i = (k == 0);
         last_i  = (k == n - 1);
         cmd_i   = (k == 0) ? c : 4'($urandom); // R8: later codes ignored
         addr_i  = ad;
         free_i  = FW'(fr0 - k);
         cls_i   = cls;
         #1;
         check_bit(full ? "R3 disc" : (bnd ? "R2 disc" : "R5/R6 disc"), disc_o, bnd || full);
         check_bit("R7 vld idle", cmd_vld_o, 1'b0);
         if (ends) begin
            if (c == C_MWI) exp_cmd = bnd ? C_MWI : C_MW;
            break;
         end
      end
      @(negedge clk);
      valid_i = 1'b0;
      first_i = 1'b0;
      last_i  = 1'b0;
      #1;
      check_bit("R7 vld pulse", cmd_vld_o, 1'b1);
      check_cmd(tag, cmd_o, exp_cmd);
      check_bit("R9 idle disc", disc_o, 1'b0);
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [CW-1:0] sizes [8];
      void'($urandom(32'd4711));
      sizes = '{8'd1, 8'd2, 8'd4, 8'd8, 8'd16, 8'd32, 8'd12, 8'd0};
      repeat (3) @(posedge clk);
      #1;
      check_bit("R9 reset vld", cmd_vld_o, 1'b0);
      check_bit("R9 reset disc", disc_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_bit("R9 after reset vld", cmd_vld_o, 1'b0);

      run_burst(C_MWI, 30'h10, 20, 8'd8, 60, "R4 full line");
      run_burst(C_MWI, 30'h40, 20, 8'd16, 5, "R4 buffer full early");
      run_burst(C_MWI, 30'h08, 10, 8'd4, 4, "R4 full on boundary");
      run_burst(C_MWI, 30'h20, 3, 8'd8, 40, "R4 initiator stops short");
      run_burst(C_MWI, 30'h03, 12, 8'd8, 40, "R5 unaligned start");
      run_burst(C_MWI, 30'h00, 10, 8'd12, 40, "R1 size 12");
      run_burst(C_MWI, 30'h00, 10, 8'd64, 40, "R1 size 64");
      run_burst(C_MWI, 30'h00, 10, 8'd0, 40, "R1 size 0");
      run_burst(C_MWI, 30'h05, 4, 8'd1, 40, "R1 size 1");
      run_burst(C_MWI, 30'h60, 40, 8'd32, 60, "R2 size 32");
      run_burst(C_MW, 30'h10, 20, 8'd8, 60, "R6 plain write");
      run_burst(4'h3, 30'h00, 5, 8'd4, 3, "R6 other code full");
      run_burst(C_MWI, 30'h30, 16, 8'd16, 40, "R8 mid-burst code");

      for (int i = 0; i < 300; i++) begin
         logic [3:0] c = ($urandom % 3 == 0) ? C_MW : C_MWI;
         logic [AW-1:0] a0 = AW'($urandom);
         if ($urandom % 2 == 0) a0[4:0] = 5'd0;
         run_burst(c, a0, 1 + int'($urandom % 40), sizes[$urandom % 8],
                   1 + int'($urandom % 48), "R4 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule